// File: doc/BRIEF.md
# SCSI Phase Checker and Interrupt Unit

This block watches the sampled control lines of a SCSI bus while a host-issued transfer command is in progress. For every command that moves bytes in a given bus phase, it compares the phase that the target presents against the phase the command expects. It sorts every outcome into one of three places: an exception register for bus events the host must handle, an error register for protocol faults, or a command-done interrupt. The three interrupt bits pass through a per-bit mask and drive a single interrupt line.

A command is written as a 4-bit code with a one-cycle valid strobe. Arbitration, selection and the six transfer commands hold the unit busy until they finish or fail. Every other code completes at once. A selection timer loads when selection starts and counts down on an external 10 ms tick. A data mover elsewhere signals the end of a transfer phase. Bus lines arrive already synchronised.

Top module: `phase_guard`

## Requirements
- R1: After reset the unit is idle (busy low) and the exception, error, interrupt and mask registers are all zero, so the interrupt line is low.
- R2: The bus phase is {MSG, C/D, I/O}. Command codes 3, 4, 5, 6, 7 and 8 expect the phases 010 (command), 011 (status), 000 (data-out), 001 (data-in), 110 (message-out) and 111 (message-in). Consider an edge at which the unit is busy with one of these codes, the phase matches, phase_end is high and no fault is present. At that edge busy drops, and at the following edge interrupt bit 0 (done) sets.
- R3: At any edge during such a transfer where the phase differs from the expected one, exception bit 1 sets, interrupt bit 1 sets, busy drops and no done is raised.
- R4: A command strobed while the unit is busy is ignored: the running command continues unchanged. At the same edge, error bit 4 and interrupt bit 2 set.
- R5: parity_err high during a transfer sets error bit 0 and interrupt bit 2, and aborts the command.
- R6: bus_rst high at any edge sets error bit 5 and interrupt bit 2, and aborts any running command.
- R7: BSY low during a transfer sets error bit 6 (target vanished) and interrupt bit 2, and aborts the command.
- R8: Code 1 (arbitrate) completes on arb_won with a done interrupt. arb_lost sets exception bit 2 and interrupt bit 1.
- R9: Code 2 (select) loads the timer from sel_limit and completes when BSY is high. Each tick decrements the timer. The tick that takes it from 1 to 0 while BSY is low sets exception bit 0 and interrupt bit 1, and aborts the selection.
- R10: With sel_limit zero, a selection never times out, however many ticks arrive.
- R11: Codes 0 and 9 to 15 never set busy. Interrupt bit 0 sets at the second edge after the strobe.
- R12: irq_o is the OR of the interrupt bits ANDed with the mask bits. Writing a 1 to interrupt bit 1 or bit 2 clears that bit and the whole exception or error register behind it. A 1 written to bit 0 clears done. A new event at the same edge as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | one-cycle command strobe |
| cmd_code | input | 4 | command code |
| bus_msg | input | 1 | sampled MSG line |
| bus_cd | input | 1 | sampled C/D line |
| bus_io | input | 1 | sampled I/O line |
| bus_bsy | input | 1 | sampled BSY line |
| bus_rst | input | 1 | sampled RST line |
| parity_err | input | 1 | parity fault pulse from the data path |
| phase_end | input | 1 | requested transfer phase finished |
| arb_won | input | 1 | arbitration won pulse |
| arb_lost | input | 1 | arbitration lost pulse |
| tick_10ms | input | 1 | one-cycle prescaler tick, every 10 ms |
| sel_limit | input | TMO_W | selection timeout in ticks, 0 = off |
| mask_we | input | 1 | write strobe for the mask |
| mask_wdata | input | 3 | new mask value |
| iclr_we | input | 1 | write-one-to-clear strobe for the interrupt bits |
| iclr_data | input | 3 | bits to clear |
| busy_o | output | 1 | a command is running |
| exc_o | output | 3 | exception register |
| err_o | output | 7 | error register |
| int_o | output | 3 | interrupt register |
| irq_o | output | 1 | masked interrupt line |

## Verification
The bench builds the unit with TMO_W = 4, so sel_limit tops out at 15 ticks. The bench can therefore run the selection timer from its largest load down to expiry in a few hundred cycles, and also check the limit of 3 and the disabled value 0. All six phase codes are tried with matching and mismatching bus phases. Directed cases cover two events at one edge: a clear that meets a new error, and a new command that meets a running one.

// File: rtl/phase_guard_pkg.sv
package phase_guard_pkg;

  localparam logic [3:0] OP_ARB = 4'd1;
  localparam logic [3:0] OP_SEL = 4'd2;

  localparam int EXC_TMO  = 0;
  localparam int EXC_PHM  = 1;
  localparam int EXC_ARB  = 2;
  localparam int ERR_PAR  = 0;
  localparam int ERR_SEQ  = 4;
  localparam int ERR_RST  = 5;
  localparam int ERR_DISC = 6;
  localparam int INT_DONE = 0;
  localparam int INT_EXC  = 1;
  localparam int INT_ERR  = 2;

  // transfer commands occupy codes 3..8
  function automatic logic is_xfer(input logic [3:0] c);
    return (c >= 4'd3) && (c <= 4'd8);
  endfunction

  // commands that keep the unit busy
  function automatic logic is_long(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd8);
  endfunction

  // bus phase {MSG, C/D, I/O} expected by a transfer command
  function automatic logic [2:0] want_phase(input logic [3:0] c);
    case (c)
      4'd3:    return 3'b010;
      4'd4:    return 3'b011;
      4'd5:    return 3'b000;
      4'd6:    return 3'b001;
      4'd7:    return 3'b110;
      4'd8:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pg_sel_timer.sv
module pg_sel_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] limit,
  input  logic             tick,
  input  logic             armed,
  output logic             expire
);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q;

  assign expire = armed && tick && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= limit;
    else if (armed && tick && (cnt_q != '0))
      cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/pg_irq_unit.sv
module pg_irq_unit #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_data,
  output logic [N_SRC-1:0] int_q,
  output logic [N_SRC-1:0] mask_q,
  output logic             irq
);
  logic [N_SRC-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_data : '0;
  assign irq     = |(int_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= '0;
      mask_q <= '0;
    end else begin
      int_q <= (int_q & ~clr_eff) | set_vec;   // a new event beats a clear
      if (mask_we) mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/phase_guard.sv
module phase_guard
  import phase_guard_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic             bus_msg,
  input  logic             bus_cd,
  input  logic             bus_io,
  input  logic             bus_bsy,
  input  logic             bus_rst,
  input  logic             parity_err,
  input  logic             phase_end,
  input  logic             arb_won,
  input  logic             arb_lost,
  input  logic             tick_10ms,
  input  logic [TMO_W-1:0] sel_limit,
  input  logic             mask_we,
  input  logic [2:0]       mask_wdata,
  input  logic             iclr_we,
  input  logic [2:0]       iclr_data,
  output logic             busy_o,
  output logic [2:0]       exc_o,
  output logic [6:0]       err_o,
  output logic [2:0]       int_o,
  output logic             irq_o
);
  localparam int N_EXC = 3;
  localparam int N_ERR = 7;

  logic             busy_q, done_d;
  logic [3:0]       op_q;
  logic [N_EXC-1:0] exc_q, exc_set;
  logic [N_ERR-1:0] err_q, err_set;
  logic [2:0]       int_set, mask_q;
  logic [2:0]       phase;

  // named events, brought out for the checker
  logic xfer_act, sel_act, arb_act;
  logic ev_phm, ev_par, ev_disc, ev_rst, ev_seq, ev_arbl, ev_tmo;
  logic tmo_expire, accept, quick, finish, abort_cmd;

  assign phase    = {bus_msg, bus_cd, bus_io};
  assign xfer_act = busy_q && is_xfer(op_q);
  assign sel_act  = busy_q && (op_q == OP_SEL);
  assign arb_act  = busy_q && (op_q == OP_ARB);

  assign ev_phm  = xfer_act && (phase != want_phase(op_q));
  assign ev_par  = xfer_act && parity_err;
  assign ev_disc = xfer_act && !bus_bsy;
  assign ev_rst  = bus_rst;
  assign ev_seq  = busy_q && cmd_valid;
  assign ev_arbl = arb_act && arb_lost;
  assign ev_tmo  = tmo_expire && !bus_bsy;

  assign accept    = cmd_valid && !busy_q;
  assign quick     = accept && !is_long(cmd_code);
  assign abort_cmd = ev_phm || ev_par || ev_disc || ev_rst || ev_arbl || ev_tmo;
  assign finish    = !abort_cmd &&
                     ((xfer_act && phase_end) || (sel_act && bus_bsy) ||
                      (arb_act && arb_won));

  pg_sel_timer #(.TMO_W(TMO_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && (cmd_code == OP_SEL)),
    .limit  (sel_limit),
    .tick   (tick_10ms),
    .armed  (sel_act),
    .expire (tmo_expire)
  );

  always_comb begin
    exc_set          = '0;
    exc_set[EXC_TMO] = ev_tmo;
    exc_set[EXC_PHM] = ev_phm;
    exc_set[EXC_ARB] = ev_arbl;
    err_set           = '0;
    err_set[ERR_PAR]  = ev_par;
    err_set[ERR_SEQ]  = ev_seq;
    err_set[ERR_RST]  = ev_rst;
    err_set[ERR_DISC] = ev_disc;
    int_set           = '0;
    int_set[INT_DONE] = done_d;
    int_set[INT_EXC]  = |exc_set;
    int_set[INT_ERR]  = |err_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      done_d <= 1'b0;
      exc_q  <= '0;
      err_q  <= '0;
    end else begin
      done_d <= finish || quick;
      if (accept && !quick) begin
        busy_q <= 1'b1;
        op_q   <= cmd_code;
      end else if (abort_cmd || finish) begin
        busy_q <= 1'b0;
      end
      exc_q <= ((iclr_we && iclr_data[INT_EXC]) ? '0 : exc_q) | exc_set;
      err_q <= ((iclr_we && iclr_data[INT_ERR]) ? '0 : err_q) | err_set;
    end
  end

  pg_irq_unit #(.N_SRC(3)) irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (int_set),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .clr_we     (iclr_we),
    .clr_data   (iclr_data),
    .int_q      (int_o),
    .mask_q     (mask_q),
    .irq        (irq_o)
  );

  assign busy_o = busy_q;
  assign exc_o  = exc_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pg_checker.sv
module pg_checker
  import phase_guard_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       bus_msg,
  input logic       bus_cd,
  input logic       bus_io,
  input logic       bus_bsy,
  input logic       bus_rst,
  input logic       parity_err,
  input logic       phase_end,
  input logic       busy_o,
  input logic [2:0] exc_o,
  input logic [6:0] err_o,
  input logic [2:0] int_o,
  input logic       irq_o,
  input logic [3:0] op_q,
  input logic [2:0] mask_q,
  input logic       tmo_expire
);
  logic [2:0] ph;
  assign ph = {bus_msg, bus_cd, bus_io};

  AST_DONE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && is_xfer(op_q) && (ph == want_phase(op_q)) && phase_end &&
    bus_bsy && !bus_rst && !parity_err |=> !busy_o ##1 int_o[0]); // R2

  AST_PHASE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && is_xfer(op_q) && (ph != want_phase(op_q))
    |=> exc_o[1] && int_o[1] && !busy_o); // R3

  AST_SEQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && cmd_valid |=> err_o[4] && int_o[2]); // R4

  AST_RST_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst && !cmd_valid |=> err_o[5] && !busy_o); // R6

  AST_EXPIRE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expire |-> busy_o && (op_q == OP_SEL)); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != 3'b000) && (int_o != 3'b000)); // R12
endmodule

bind phase_guard pg_checker #(.TMO_W(TMO_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .bus_msg    (bus_msg),
  .bus_cd     (bus_cd),
  .bus_io     (bus_io),
  .bus_bsy    (bus_bsy),
  .bus_rst    (bus_rst),
  .parity_err (parity_err),
  .phase_end  (phase_end),
  .busy_o     (busy_o),
  .exc_o      (exc_o),
  .err_o      (err_o),
  .int_o      (int_o),
  .irq_o      (irq_o),
  .op_q       (op_q),
  .mask_q     (mask_q),
  .tmo_expire (tmo_expire)
);

// File: tb/phase_guard_tb_top.sv
module phase_guard_tb_top;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_code = '0;
  logic          bus_msg = 1'b0, bus_cd = 1'b0, bus_io = 1'b0;
  logic          bus_bsy = 1'b1, bus_rst = 1'b0, parity_err = 1'b0;
  logic          phase_end = 1'b0, arb_won = 1'b0, arb_lost = 1'b0;
  logic          tick_10ms = 1'b0;
  logic [TW-1:0] sel_limit = '0;
  logic          mask_we = 1'b0;
  logic [2:0]    mask_wdata = '0;
  logic          iclr_we = 1'b0;
  logic [2:0]    iclr_data = '0;
  logic          busy_o, irq_o;
  logic [2:0]    exc_o, int_o;
  logic [6:0]    err_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // {code, phase {MSG,C/D,I/O}, phase matches}
  localparam logic [7:0] VEC [12] = '{
    {4'd3, 3'b010, 1'b1}, {4'd4, 3'b011, 1'b1}, {4'd5, 3'b000, 1'b1},
    {4'd6, 3'b001, 1'b1}, {4'd7, 3'b110, 1'b1}, {4'd8, 3'b111, 1'b1},
    {4'd3, 3'b011, 1'b0}, {4'd5, 3'b001, 1'b0}, {4'd7, 3'b111, 1'b0},
    {4'd8, 3'b000, 1'b0}, {4'd6, 3'b010, 1'b0}, {4'd4, 3'b110, 1'b0}
  };

  always #5 clk = ~clk;

  phase_guard #(.TMO_W(TW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] code);
    cmd_valid = 1'b1;
    cmd_code  = code;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic clear_all();
    iclr_we   = 1'b1;
    iclr_data = 3'b111;
    step();
    iclr_we = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      tick_10ms = 1'b1;
      step();
      tick_10ms = 1'b0;
      step();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 exc", exc_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 int", int_o, 0);
    chk("R1 irq", irq_o, 0);

    // vector table: R2 matching phases, R3 mismatching phases
    for (int i = 0; i < 12; i++) begin
      {bus_msg, bus_cd, bus_io} = VEC[i][3:1];
      issue(VEC[i][7:4]);
      chk("R2 busy after issue", busy_o, 1);
      if (VEC[i][0]) begin
        phase_end = 1'b1;
        step();
        phase_end = 1'b0;
        chk("R2 busy drops", busy_o, 0);
        chk("R2 done not yet", int_o, 3'b000);
        step();
        chk("R2 done set", int_o, 3'b001);
        chk("R2 no exception", exc_o, 3'b000);
      end else begin
        step();
        chk("R3 busy drops", busy_o, 0);
        chk("R3 exc", exc_o, 3'b010);
        chk("R3 int", int_o, 3'b010);
        step();
        chk("R3 no done", int_o, 3'b010);
      end
      clear_all();
      chk("R12 cleared int", int_o, 0);
      chk("R12 cleared exc", exc_o, 0);
    end

    // R4: a second command while busy is ignored and flagged
    {bus_msg, bus_cd, bus_io} = 3'b010;
    issue(4'd3);
    issue(4'd5);
    chk("R4 err", err_o, 7'h10);
    chk("R4 int", int_o, 3'b100);
    chk("R4 still busy", busy_o, 1);
    step();
    chk("R4 running cmd kept", exc_o, 0);
    // R12: clear of int bit 2 at the same edge as a new seq error loses
    cmd_valid = 1'b1; cmd_code = 4'd6; iclr_we = 1'b1; iclr_data = 3'b100;
    step();
    cmd_valid = 1'b0; iclr_we = 1'b0;
    chk("R12 set wins", int_o, 3'b100);
    phase_end = 1'b1;
    step();
    phase_end = 1'b0;
    step();
    chk("R4 original finishes", int_o, 3'b101);
    // R12 mask gating
    chk("R12 irq masked", irq_o, 0);
    mask_we = 1'b1; mask_wdata = 3'b001;
    step();
    mask_we = 1'b0;
    chk("R12 irq on", irq_o, 1);
    iclr_we = 1'b1; iclr_data = 3'b001;
    step();
    iclr_we = 1'b0;
    chk("R12 irq off after clear", irq_o, 0);
    chk("R12 err kept", err_o, 7'h10);
    clear_all();
    chk("R12 err cleared", err_o, 0);

    // R5 parity
    {bus_msg, bus_cd, bus_io} = 3'b011;
    issue(4'd4);
    parity_err = 1'b1;
    step();
    parity_err = 1'b0;
    chk("R5 err", err_o, 7'h01);
    chk("R5 int", int_o, 3'b100);
    chk("R5 busy", busy_o, 0);
    clear_all();

    // R7 disconnect
    issue(4'd4);
    bus_bsy = 1'b0;
    step();
    bus_bsy = 1'b1;
    chk("R7 err", err_o, 7'h40);
    chk("R7 busy", busy_o, 0);
    clear_all();

    // R6 bus reset while idle and while busy
    bus_rst = 1'b1;
    step();
    bus_rst = 1'b0;
    chk("R6 err idle", err_o, 7'h20);
    chk("R6 int", int_o, 3'b100);
    clear_all();
    issue(4'd4);
    bus_rst = 1'b1;
    step();
    bus_rst = 1'b0;
    chk("R6 abort", busy_o, 0);
    clear_all();

    // R8 arbitration
    issue(4'd1);
    chk("R8 busy", busy_o, 1);
    arb_won = 1'b1;
    step();
    arb_won = 1'b0;
    chk("R8 won busy", busy_o, 0);
    step();
    chk("R8 won done", int_o, 3'b001);
    clear_all();
    issue(4'd1);
    arb_lost = 1'b1;
    step();
    arb_lost = 1'b0;
    chk("R8 lost exc", exc_o, 3'b100);
    chk("R8 lost int", int_o, 3'b010);
    clear_all();

    // R9 selection timeout with limit 3
    bus_bsy = 1'b0;
    sel_limit = 4'd3;
    issue(4'd2);
    tick_n(2);
    chk("R9 no timeout yet", exc_o, 0);
    chk("R9 still busy", busy_o, 1);
    tick_n(1);
    chk("R9 timeout exc", exc_o, 3'b001);
    chk("R9 timeout int", int_o, 3'b010);
    chk("R9 aborted", busy_o, 0);
    clear_all();
    // R9 largest limit
    sel_limit = 4'd15;
    issue(4'd2);
    tick_n(14);
    chk("R9 max no timeout", exc_o, 0);
    tick_n(1);
    chk("R9 max timeout", exc_o, 3'b001);
    clear_all();
    // R9 selection answered
    sel_limit = 4'd3;
    issue(4'd2);
    tick_n(1);
    bus_bsy = 1'b1;
    step();
    chk("R9 answered busy", busy_o, 0);
    step();
    chk("R9 answered done", int_o, 3'b001);
    chk("R9 answered no exc", exc_o, 0);
    clear_all();

    // R10 timeout disabled
    bus_bsy = 1'b0;
    sel_limit = 4'd0;
    issue(4'd2);
    tick_n(20);
    chk("R10 no timeout", exc_o, 0);
    chk("R10 busy", busy_o, 1);
    bus_bsy = 1'b1;
    step();
    step();
    chk("R10 finishes", int_o, 3'b001);
    clear_all();

    // R11 single-cycle codes
    issue(4'd9);
    chk("R11 not busy", busy_o, 0);
    chk("R11 done not yet", int_o, 0);
    step();
    chk("R11 done", int_o, 3'b001);
    clear_all();
    issue(4'd0);
    step();
    chk("R11 code0 done", int_o, 3'b001);
    chk("R11 code0 irq", irq_o, 1);
    clear_all();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule